// File: doc/BRIEF.md
# DMA Linear Copy Packet Splitter

This block takes one memory-to-memory copy request and turns it into a stream of linear-copy command packets for a DMA engine. A request carries a 64-bit source address, a 64-bit destination address, a byte count and a format select. The block cuts the byte count into chunks no larger than a per-format limit. For each chunk it emits a seven-word packet, one 32-bit word per valid/ready handshake. It raises a one-cycle completion pulse once the engine has taken the final word.

When both addresses start on a 4-byte boundary but the byte count does not, the block sends the bulk of the copy in chunks that are whole multiples of four bytes. It then closes with a short tail packet that holds the leftover one to three bytes. This lets the engine use its fast word-wide copy path for almost all of the data. The format select picks two things: whether the size word carries the chunk length minus one or the plain length, and which per-packet limit applies. MAX_NEW and MAX_OLD must both be multiples of 4.

States: ST_IDLE (waiting for a request), ST_SEND (streaming packet words) and ST_DONE (one-cycle completion). Transitions: ST_IDLE to ST_SEND on a request with a nonzero count. ST_IDLE to ST_DONE on a request with a zero count. ST_SEND to ST_DONE when the last word of the packet that empties the remaining count is accepted. ST_DONE to ST_IDLE always.

Top module: `dma_copy_splitter`

## Requirements
- R1: A request with a byte count of zero produces no packet words, and done_o pulses in the cycle after the request is accepted.
- R2: Every packet is exactly seven words, in this fixed order: header, size, swap word, source low, source high, destination low, destination high. The swap word is always zero.
- R3: The header word carries parameter OPCODE in bits 7:0 and parameter SUBOP in bits 15:8. All other bits are zero, including the secure-copy flag at bit 18.
- R4: Without the alignment split, each chunk is the smaller of the remaining count and the packet limit. The limit is MAX_NEW when req_fmt_new was 1 and MAX_OLD when it was 0.
- R5: When both start addresses have bits 1:0 equal to zero, the count exceeds 4, and the count is not a multiple of 4, every chunk taken while 4 or more bytes remain is the remaining count rounded down to a multiple of 4, capped at the limit.
- R6: Once fewer than 4 bytes remain, the next chunk is the whole remainder.
- R7: With req_fmt_new = 1 the size word holds the chunk length minus one. With req_fmt_new = 0 it holds the chunk length.
- R8: After each packet, both addresses advance by the chunk length with full 64-bit carry, and the remaining count drops by the same amount.
- R9: Packets continue until the remaining count reaches zero, so the chunk lengths of one request sum exactly to its byte count and no zero-length packet is sent.
- R10: While pkt_valid is high and pkt_ready is low, pkt_word holds steady. The word position advances only on a completed handshake.
- R11: req_ready is high only in ST_IDLE, pkt_valid is low there, and done_o is a single-cycle pulse in the cycle after the last word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_src | input | 64 | Source byte address |
| req_dst | input | 64 | Destination byte address |
| req_bytes | input | CNT_W | Byte count |
| req_fmt_new | input | 1 | 1: size word is length minus one and limit is MAX_NEW; 0: plain length and MAX_OLD |
| pkt_valid | output | 1 | Packet word present |
| pkt_ready | input | 1 | Engine accepts the packet word |
| pkt_word | output | 32 | Packet word |
| done_o | output | 1 | One-cycle pulse when a request has been fully emitted |

## Verification
The bench builds the block with limits of 16 bytes for the new format and 12 bytes for the old format, and a 16-bit count. With these values, byte counts from 0 to 44 span zero, tail-only, single-packet, multi-packet and split-with-tail cases in both formats. The sweep is crossed with aligned and unaligned address pairs and three backpressure patterns. A source and destination placed just below a 32-bit boundary and at the top of the 64-bit space bring carries between the address words into reach within a few packets.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_DONE = 2'd2
    } split_state_t;

    localparam int PKT_WORDS = 7;

    typedef enum logic [2:0] {
        W_HDR    = 3'd0,
        W_SIZE   = 3'd1,
        W_SWAP   = 3'd2,
        W_SRC_LO = 3'd3,
        W_SRC_HI = 3'd4,
        W_DST_LO = 3'd5,
        W_DST_HI = 3'd6
    } word_sel_t;

endpackage

// File: rtl/dma_split_chunk.sv
module dma_split_chunk #(
    parameter int CNT_W   = 32,
    parameter int MAX_NEW = 4194048,
    parameter int MAX_OLD = 2097120
) (
    input  logic [CNT_W-1:0] remaining,
    input  logic             split_mode,
    input  logic             fmt_new,
    output logic [CNT_W-1:0] chunk,
    output logic [31:0]      size_field
);
    localparam logic [CNT_W-1:0] LIM_NEW = CNT_W'(MAX_NEW);
    localparam logic [CNT_W-1:0] LIM_OLD = CNT_W'(MAX_OLD);
    localparam logic [CNT_W-1:0] FOUR    = CNT_W'(4);

    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] masked;

    always_comb begin
        limit  = fmt_new ? LIM_NEW : LIM_OLD;
        masked = split_mode ? {remaining[CNT_W-1:2], 2'b00} : remaining;
        if (remaining < FOUR) begin
            chunk = remaining;
        end else if (masked < limit) begin
            chunk = masked;
        end else begin
            chunk = limit;
        end
        size_field = 32'(chunk) - {31'd0, fmt_new};
    end
endmodule

// File: rtl/dma_split_advance.sv
module dma_split_advance #(
    parameter int CNT_W = 32
) (
    input  logic [63:0]      src,
    input  logic [63:0]      dst,
    input  logic [CNT_W-1:0] remaining,
    input  logic [CNT_W-1:0] chunk,
    output logic [63:0]      nxt_src,
    output logic [63:0]      nxt_dst,
    output logic [CNT_W-1:0] nxt_rem,
    output logic             final_chunk
);
    always_comb begin
        nxt_src     = src + 64'(chunk);
        nxt_dst     = dst + 64'(chunk);
        nxt_rem     = remaining - chunk;
        final_chunk = (nxt_rem == '0);
    end
endmodule

// File: rtl/dma_split_word.sv
module dma_split_word
    import dma_split_pkg::*;
#(
    parameter logic [7:0] OPCODE = 8'h01,
    parameter logic [7:0] SUBOP  = 8'h00
) (
    input  word_sel_t   sel,
    input  logic [31:0] size_field,
    input  logic [63:0] src,
    input  logic [63:0] dst,
    output logic [31:0] word
);
    localparam logic SECURE = 1'b0;
    localparam logic [31:0] HEADER = {13'd0, SECURE, 2'b00, SUBOP, OPCODE};

    always_comb begin
        unique case (sel)
            W_HDR:    word = HEADER;
            W_SIZE:   word = size_field;
            W_SWAP:   word = 32'd0;
            W_SRC_LO: word = src[31:0];
            W_SRC_HI: word = src[63:32];
            W_DST_LO: word = dst[31:0];
            W_DST_HI: word = dst[63:32];
            default:  word = 32'd0;
        endcase
    end
endmodule

// File: rtl/dma_copy_splitter.sv
module dma_copy_splitter
    import dma_split_pkg::*;
#(
    parameter logic [7:0] OPCODE  = 8'h01,
    parameter logic [7:0] SUBOP   = 8'h00,
    parameter int         CNT_W   = 32,
    parameter int         MAX_NEW = 4194048,
    parameter int         MAX_OLD = 2097120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [63:0]      req_src,
    input  logic [63:0]      req_dst,
    input  logic [CNT_W-1:0] req_bytes,
    input  logic             req_fmt_new,
    output logic             pkt_valid,
    input  logic             pkt_ready,
    output logic [31:0]      pkt_word,
    output logic             done_o
);
    localparam word_sel_t        LAST_SEL = word_sel_t'(PKT_WORDS - 1);
    localparam logic [CNT_W-1:0] FOUR     = CNT_W'(4);

    split_state_t     state_q, state_d;
    word_sel_t        idx_q;
    logic [63:0]      src_q, dst_q;
    logic [CNT_W-1:0] rem_q;
    logic             fmt_q, split_q;

    logic [CNT_W-1:0] chunk;
    logic [31:0]      size_field;
    logic [63:0]      nxt_src, nxt_dst;
    logic [CNT_W-1:0] nxt_rem;
    logic             final_chunk;
    logic             accept, hs, pkt_end, split_req;

    dma_split_chunk #(
        .CNT_W  (CNT_W),
        .MAX_NEW(MAX_NEW),
        .MAX_OLD(MAX_OLD)
    ) u_chunk (
        .remaining (rem_q),
        .split_mode(split_q),
        .fmt_new   (fmt_q),
        .chunk     (chunk),
        .size_field(size_field)
    );

    dma_split_advance #(
        .CNT_W(CNT_W)
    ) u_adv (
        .src        (src_q),
        .dst        (dst_q),
        .remaining  (rem_q),
        .chunk      (chunk),
        .nxt_src    (nxt_src),
        .nxt_dst    (nxt_dst),
        .nxt_rem    (nxt_rem),
        .final_chunk(final_chunk)
    );

    dma_split_word #(
        .OPCODE(OPCODE),
        .SUBOP (SUBOP)
    ) u_word (
        .sel       (idx_q),
        .size_field(size_field),
        .src       (src_q),
        .dst       (dst_q),
        .word      (pkt_word)
    );

    // Output process
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        pkt_valid = (state_q == ST_SEND);
        done_o    = (state_q == ST_DONE);
    end

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign hs        = pkt_valid && pkt_ready;
    assign pkt_end   = hs && (idx_q == LAST_SEL);
    assign split_req = (req_src[1:0] == 2'b00) && (req_dst[1:0] == 2'b00) &&
                       (req_bytes > FOUR) && (req_bytes[1:0] != 2'b00);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = (req_bytes == '0) ? ST_DONE : ST_SEND;
            ST_SEND: if (pkt_end && final_chunk) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request and packet bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= W_HDR;
            src_q   <= '0;
            dst_q   <= '0;
            rem_q   <= '0;
            fmt_q   <= 1'b0;
            split_q <= 1'b0;
        end else if (accept) begin
            idx_q   <= W_HDR;
            src_q   <= req_src;
            dst_q   <= req_dst;
            rem_q   <= req_bytes;
            fmt_q   <= req_fmt_new;
            split_q <= split_req;
        end else if (hs) begin
            if (pkt_end) begin
                idx_q <= W_HDR;
                src_q <= nxt_src;
                dst_q <= nxt_dst;
                rem_q <= nxt_rem;
            end else begin
                idx_q <= word_sel_t'(idx_q + 3'd1);
            end
        end
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_word));

    // R9
    chunk_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) |-> (chunk != '0) && (chunk <= rem_q));

    // R4
    chunk_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) |-> (chunk <= (fmt_q ? CNT_W'(MAX_NEW) : CNT_W'(MAX_OLD))));

    // R5
    bulk_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) && split_q && (rem_q >= FOUR) |-> (chunk[1:0] == 2'b00));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && req_ready);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !pkt_valid && !done_o);

    // R2
    swap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && (idx_q == W_SWAP) |-> (pkt_word == 32'd0));

endmodule

// File: tb/dma_copy_splitter_tb.sv
module dma_copy_splitter_tb;
    localparam logic [7:0] OPC   = 8'h01;
    localparam logic [7:0] SUB   = 8'h5A;
    localparam int         CW    = 16;
    localparam int         MXNEW = 16;
    localparam int         MXOLD = 12;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            req_valid;
    logic            req_ready;
    logic [63:0]     req_src, req_dst;
    logic [CW-1:0]   req_bytes;
    logic            req_fmt_new;
    logic            pkt_valid;
    logic            pkt_ready;
    logic [31:0]     pkt_word;
    logic            done_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    dma_copy_splitter #(
        .OPCODE (OPC),
        .SUBOP  (SUB),
        .CNT_W  (CW),
        .MAX_NEW(MXNEW),
        .MAX_OLD(MXOLD)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_src    (req_src),
        .req_dst    (req_dst),
        .req_bytes  (req_bytes),
        .req_fmt_new(req_fmt_new),
        .pkt_valid  (pkt_valid),
        .pkt_ready  (pkt_ready),
        .pkt_word   (pkt_word),
        .done_o     (done_o)
    );

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog expired act=%0d exp=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic run_req(input logic [63:0] s, input logic [63:0] d, input int n,
                           input bit fm, input int stall);
        logic [63:0] es = s;
        logic [63:0] ed = d;
        int er = n;
        bit sp = (s[1:0] == 2'b00) && (d[1:0] == 2'b00) && (n > 4) && (n % 4 != 0);
        int lim = fm ? MXNEW : MXOLD;
        int idx = 0;
        int sum = 0;
        bit expect_done = (n == 0);
        bit got_done = 1'b0;
        bit held = 1'b0;
        logic [31:0] held_w = '0;
        int guard = 0;
        int chunk;
        logic [31:0] expw;
        string tag;

        @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready in idle", 64'(req_ready), 64'd1);
        req_valid   = 1'b1;
        req_src     = s;
        req_dst     = d;
        req_bytes   = CW'(n);
        req_fmt_new = fm;
        @(negedge clk);
        req_valid = 1'b0;

        while (!got_done && guard < 3000) begin
            case (stall)
                0: pkt_ready = 1'b1;
                1: pkt_ready = lfsr[3];
                default: pkt_ready = guard[0];
            endcase
            #1;
            if (expect_done) begin
                chk(done_o == 1'b1, (n == 0) ? "R1 done after zero request" : "R11 done after last word",
                    64'(done_o), 64'd1);
                chk(pkt_valid == 1'b0, (n == 0) ? "R1 no words" : "R11 valid low at done",
                    64'(pkt_valid), 64'd0);
                got_done = 1'b1;
            end else begin
                chk(done_o == 1'b0, "R11 early done", 64'(done_o), 64'd0);
                chk(pkt_valid == 1'b1, "R9 words while bytes remain", 64'(pkt_valid), 64'd1);
                if (held && pkt_valid)
                    chk(pkt_word == held_w, "R10 word held under stall", 64'(pkt_word), 64'(held_w));
                if (er >= 4) begin
                    chunk = sp ? (er & ~3) : er;
                    if (chunk > lim) chunk = lim;
                end else begin
                    chunk = er;
                end
                case (idx)
                    0: begin expw = 32'(OPC) | (32'(SUB) << 8); tag = "R3 header"; end
                    1: begin
                        expw = fm ? 32'(chunk - 1) : 32'(chunk);
                        tag = sp ? ((er < 4) ? "R7 R6 split tail size" : "R7 R5 split bulk size")
                                 : ((er < 4) ? "R7 R6 tail size" : "R7 R4 size");
                    end
                    2: begin expw = 32'd0; tag = "R2 swap word"; end
                    3: begin expw = es[31:0];  tag = "R8 src low"; end
                    4: begin expw = es[63:32]; tag = "R8 src high"; end
                    5: begin expw = ed[31:0];  tag = "R8 dst low"; end
                    default: begin expw = ed[63:32]; tag = "R8 dst high"; end
                endcase
                if (pkt_valid && pkt_ready) begin
                    chk(pkt_word == expw, tag, 64'(pkt_word), 64'(expw));
                    held = 1'b0;
                    if (idx == 6) begin
                        es  = es + 64'(chunk);
                        ed  = ed + 64'(chunk);
                        er  = er - chunk;
                        sum = sum + chunk;
                        idx = 0;
                        if (er == 0) expect_done = 1'b1;
                    end else begin
                        idx++;
                    end
                end else if (pkt_valid) begin
                    held   = 1'b1;
                    held_w = pkt_word;
                end
            end
            @(negedge clk);
            guard++;
        end
        pkt_ready = 1'b0;
        #1;
        chk(got_done, "R9 request completed", 64'(got_done), 64'd1);
        chk(sum == n, "R9 chunk sum", 64'(sum), 64'(n));
        chk(done_o == 1'b0 && req_ready == 1'b1, "R11 single done pulse",
            64'({done_o, req_ready}), 64'b01);
    endtask

    initial begin
        logic [63:0] soff [4] = '{64'd0, 64'd0, 64'd1, 64'd2};
        logic [63:0] doff [4] = '{64'd0, 64'd3, 64'd0, 64'd2};
        rst_n       = 1'b0;
        req_valid   = 1'b0;
        req_src     = '0;
        req_dst     = '0;
        req_bytes   = '0;
        req_fmt_new = 1'b0;
        pkt_ready   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(req_ready == 1'b1 && pkt_valid == 1'b0 && done_o == 1'b0, "R11 reset state",
            64'({req_ready, pkt_valid, done_o}), 64'b100);

        for (int fm = 0; fm < 2; fm++) begin
            for (int n = 0; n <= 44; n++) begin
                for (int a = 0; a < 4; a++) begin
                    run_req(64'h0000_0000_0010_0000 + soff[a] + 64'(n * 64),
                            64'h0000_0000_0800_0000 + doff[a],
                            n, fm[0], (n + a) % 3);
                end
            end
        end
        // R8 carries across the 32-bit word boundary and 64-bit wrap
        run_req(64'h0000_0001_FFFF_FFF4, 64'hFFFF_FFFF_FFFF_FFE0, 37, 1'b1, 1);
        run_req(64'h0000_0001_FFFF_FFF4, 64'hFFFF_FFFF_FFFF_FFE0, 37, 1'b0, 2);
        run_req(64'h0000_0000_FFFF_FFFD, 64'h0000_0002_FFFF_FFF8, 29, 1'b1, 0);

        summary();
        $finish;
    end
endmodule